// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit repairs a byte that came out of a plain binary add or subtract of two packed-BCD operands, so that it again holds two valid decimal digits. It takes the raw result byte, the carry and auxiliary-carry flags that the binary operation produced, and a select that says whether that operation was an addition or a subtraction. It returns the corrected byte and a set of six status flags.

The correction has two steps. The low digit is repaired first, by six. The high digit is then repaired by 0x60, and this step acts on the byte left by the first step. Both decisions are made on the original byte and the incoming flags, not on any partly corrected value. The carry out is predicted from the original byte with fixed thresholds, so no adder carry chain is needed to produce it. All byte arithmetic wraps modulo 256.

A parameter selects whether the outputs are registered, with one cycle of latency, or driven straight from the combinational path.

Top module: `bcd_dec_adjust`

## Requirements
- R1: The low-digit step is taken when the low nibble of the original byte (bits 3:0) is greater than 9, or when the incoming auxiliary carry is 1. When taken, it adds 6 (select `sub_i`=0) or subtracts 6 (`sub_i`=1), and the auxiliary-carry output is 1. When not taken, the auxiliary-carry output is 0.
- R2: In add mode, when the low-digit step is taken, the provisional carry is 1 if the original byte is greater than 0xF9 or the incoming carry is 1. Otherwise the provisional carry is 0.
- R3: In subtract mode, when the low-digit step is taken, the provisional carry is 1 if the original byte is less than 0x06 or the incoming carry is 1. Otherwise the provisional carry is 0.
- R4: The high-digit step is taken when the original byte is greater than 0x99 or the incoming carry is 1. It adds or subtracts 0x60 on the byte left by the low-digit step, and forces the carry output to 1. When it is not taken, the carry output equals the provisional carry.
- R5: When neither step is taken, the byte passes through unchanged and both the carry and the auxiliary-carry outputs are 0.
- R6: The sign flag equals bit 7 of the final byte. The zero flag is 1 exactly when the final byte is 0x00.
- R7: The parity flag is 1 when the final byte has an even number of 1 bits, and 0 when that number is odd.
- R8: The overflow flag is always 0.
- R9: With `REG_OUT`=1, all outputs are 0 while `rst_n` is low. Otherwise the outputs show the result for the inputs present at the previous rising clock edge. With `REG_OUT`=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_i | input | 8 | Raw binary result to correct |
| sub_i | input | 1 | 0: add mode, 1: subtract mode |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming auxiliary-carry flag |
| byte_o | output | 8 | Corrected byte |
| cf_o | output | 1 | Carry flag |
| af_o | output | 1 | Auxiliary-carry flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag (1 for an even count of ones) |
| of_o | output | 1 | Overflow flag, always 0 |

## Verification
The bench builds two instances side by side, one with `REG_OUT`=1 and one with `REG_OUT`=0, and drives both with the same inputs. The combinational copy can be compared in the same cycle and the registered copy one edge later, so a single sweep of all 256 bytes under each mode and flag combination covers both the correction rules and the one-cycle latency. Directed cases fill in the rest: the carry thresholds at 0xF9/0xFA and 0x05/0x06, a byte whose high decision differs between the original and the corrected value, and the reset state of the registered copy.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = DATA_W / 2;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [NIB_W-1:0]  nib_t;

  localparam nib_t  DIGIT_MAX = nib_t'(9);
  localparam byte_t LO_STEP   = byte_t'(8'h06);
  localparam byte_t HI_STEP   = byte_t'(8'h60);
  localparam byte_t HI_LIMIT  = byte_t'(8'h99);
  localparam byte_t ADD_CY_TH = byte_t'(8'hF9);
  localparam byte_t SUB_BR_TH = byte_t'(8'h06);

  typedef struct packed {
    logic cf;
    logic af;
    logic sf;
    logic zf;
    logic pf;
    logic of;
  } flags_t;
endpackage

// File: rtl/bcd_lo_stage.sv
module bcd_lo_stage
  import bcd_adj_pkg::*;
(
  input  byte_t raw_i,
  input  logic  sub_i,
  input  logic  cf_i,
  input  logic  af_i,
  output byte_t mid_o,
  output logic  fire_o,
  output logic  prov_cf_o
);
  logic  nib_big;
  logic  edge_hit;
  byte_t stepped;

  always_comb begin
    nib_big  = (raw_i[NIB_W-1:0] > DIGIT_MAX);
    fire_o   = nib_big | af_i;
    edge_hit = sub_i ? (raw_i < SUB_BR_TH) : (raw_i > ADD_CY_TH);
    stepped  = sub_i ? (raw_i - LO_STEP) : (raw_i + LO_STEP);
    mid_o     = fire_o ? stepped : raw_i;
    prov_cf_o = fire_o & (edge_hit | cf_i);
  end

  // R5: without a correction the byte must pass through unchanged
  always_comb begin
    if (!fire_o) begin
      assert_lo_pass_R5: assert (mid_o == raw_i);
    end
  end
endmodule

// File: rtl/bcd_hi_stage.sv
module bcd_hi_stage
  import bcd_adj_pkg::*;
(
  input  byte_t raw_i,
  input  byte_t mid_i,
  input  logic  sub_i,
  input  logic  cf_i,
  input  logic  prov_cf_i,
  output byte_t fin_o,
  output logic  cf_o
);
  logic fire;

  always_comb begin
    fire  = (raw_i > HI_LIMIT) | cf_i;
    fin_o = fire ? (sub_i ? (mid_i - HI_STEP) : (mid_i + HI_STEP)) : mid_i;
    cf_o  = fire | prov_cf_i;
  end

  // R4: an incoming carry always yields an outgoing carry
  always_comb begin
    if (cf_i) begin
      assert_hi_carry_R4: assert (cf_o);
    end
  end
endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen
  import bcd_adj_pkg::*;
(
  input  byte_t  fin_i,
  input  logic   cf_i,
  input  logic   af_i,
  output flags_t flags_o
);
  always_comb begin
    flags_o.cf = cf_i;
    flags_o.af = af_i;
    flags_o.sf = fin_i[DATA_W-1];
    flags_o.zf = (fin_i == '0);
    flags_o.pf = ~(^fin_i);
    flags_o.of = 1'b0;
  end
endmodule

// File: rtl/bcd_dec_adjust.sv
module bcd_dec_adjust
  import bcd_adj_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] byte_i,
  input  logic       sub_i,
  input  logic       cf_i,
  input  logic       af_i,
  output logic [7:0] byte_o,
  output logic       cf_o,
  output logic       af_o,
  output logic       sf_o,
  output logic       zf_o,
  output logic       pf_o,
  output logic       of_o
);
  byte_t  mid;
  logic   lo_fire;
  logic   prov_cf;
  byte_t  fin;
  logic   fin_cf;
  flags_t flg_nxt;

  bcd_lo_stage u_lo (
    .raw_i     (byte_i),
    .sub_i     (sub_i),
    .cf_i      (cf_i),
    .af_i      (af_i),
    .mid_o     (mid),
    .fire_o    (lo_fire),
    .prov_cf_o (prov_cf)
  );

  bcd_hi_stage u_hi (
    .raw_i     (byte_i),
    .mid_i     (mid),
    .sub_i     (sub_i),
    .cf_i      (cf_i),
    .prov_cf_i (prov_cf),
    .fin_o     (fin),
    .cf_o      (fin_cf)
  );

  bcd_flag_gen u_flg (
    .fin_i   (fin),
    .cf_i    (fin_cf),
    .af_i    (lo_fire),
    .flags_o (flg_nxt)
  );

  byte_t  byte_q;
  flags_t flg_q;

  generate
    if (REG_OUT) begin : g_reg
      byte_t  byte_d;
      flags_t flg_d;

      always_comb begin
        byte_d = fin;
        flg_d  = flg_nxt;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          byte_q <= '0;
          flg_q  <= '0;
        end else begin
          byte_q <= byte_d;
          flg_q  <= flg_d;
        end
      end
    end else begin : g_comb
      always_comb begin
        byte_q = fin;
        flg_q  = flg_nxt;
      end
    end
  endgenerate

  always_comb begin
    byte_o = byte_q;
    cf_o   = flg_q.cf;
    af_o   = flg_q.af;
    sf_o   = flg_q.sf;
    zf_o   = flg_q.zf;
    pf_o   = flg_q.pf;
    of_o   = flg_q.of;
  end

  // Checks relating ports over time; primed after the first sampled cycle
  logic primed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  assert_of_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> !of_o);

  assert_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (sf_o == byte_o[7]));

  assert_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (pf_o == ~(^byte_o)));

  generate
    if (REG_OUT) begin : g_tchk
      assert_af_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && af_i) |=> af_o);

      assert_cf_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && cf_i) |=> cf_o);

      assert_no_adjust_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !cf_i && !af_i && (byte_i[3:0] <= 4'd9) && (byte_i <= 8'h99))
        |=> (byte_o == $past(byte_i)) && !cf_o && !af_o);

      assert_reg_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $stable(byte_i) && $stable(sub_i) && $stable(cf_i) && $stable(af_i))
        |=> $stable(byte_o));
    end
  endgenerate
endmodule

// File: tb/test_bcd_dec_adjust.sv
`timescale 1ns/1ps
module test_bcd_dec_adjust;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] byte_i;
  logic       sub_i, cf_i, af_i;
  logic [7:0] r_byte, c_byte;
  logic       r_cf, r_af, r_sf, r_zf, r_pf, r_of;
  logic       c_cf, c_af, c_sf, c_zf, c_pf, c_of;
  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  bcd_dec_adjust #(.REG_OUT(1'b1)) i_bcd_dec_adjust (
    .clk(clk), .rst_n(rst_n), .byte_i(byte_i), .sub_i(sub_i), .cf_i(cf_i), .af_i(af_i),
    .byte_o(r_byte), .cf_o(r_cf), .af_o(r_af), .sf_o(r_sf), .zf_o(r_zf), .pf_o(r_pf), .of_o(r_of)
  );

  bcd_dec_adjust #(.REG_OUT(1'b0)) i_bcd_dec_adjust_comb (
    .clk(clk), .rst_n(rst_n), .byte_i(byte_i), .sub_i(sub_i), .cf_i(cf_i), .af_i(af_i),
    .byte_o(c_byte), .cf_o(c_cf), .af_o(c_af), .sf_o(c_sf), .zf_o(c_zf), .pf_o(c_pf), .of_o(c_of)
  );

  // Expected packed value {byte, cf, af, sf, zf, pf, of}, built from the requirements
  function automatic logic [13:0] model(input logic [7:0] b, input logic s, input logic ci, input logic ai);
    logic [7:0] v;
    logic lo, hi, pc;
    lo = (b[3:0] > 4'd9) || ai;
    pc = 1'b0;
    v  = b;
    if (lo) begin
      pc = s ? ((b < 8'h06) || ci) : ((b > 8'hF9) || ci);
      v  = s ? v - 8'h06 : v + 8'h06;
    end
    hi = (b > 8'h99) || ci;
    if (hi) v = s ? v - 8'h60 : v + 8'h60;
    model = {v, hi | pc, lo, v[7], (v == 8'h00), ~(^v), 1'b0};
  endfunction

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (byte=%h sub=%b cf=%b af=%b)",
               req, act, exp, byte_i, sub_i, cf_i, af_i);
    end
  endtask

  function automatic logic [13:0] reg_out();
    reg_out = {r_byte, r_cf, r_af, r_sf, r_zf, r_pf, r_of};
  endfunction
  function automatic logic [13:0] comb_out();
    comb_out = {c_byte, c_cf, c_af, c_sf, c_zf, c_pf, c_of};
  endfunction

  task automatic apply(input logic [7:0] b, input logic s, input logic ci, input logic ai);
    @(negedge clk);
    byte_i = b; sub_i = s; cf_i = ci; af_i = ai;
    #1;
  endtask

  // R9: reset state of the registered copy
  task automatic t_reset();
    rst_n = 1'b0;
    apply(8'hFF, 1'b0, 1'b1, 1'b1);
    @(posedge clk); #1;
    check("R9 reset", reg_out(), 14'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1..R8 full sweep, R9 latency on the registered copy
  task automatic t_sweep();
    for (int m = 0; m < 8; m++) begin
      for (int b = 0; b < 256; b++) begin
        apply(8'(b), m[2], m[1], m[0]);
        check("R1-sweep comb", comb_out(), model(8'(b), m[2], m[1], m[0]));
        @(posedge clk); #1;
        check("R9 sweep reg", reg_out(), model(8'(b), m[2], m[1], m[0]));
      end
    end
  endtask

  task automatic t_corner(input string req, input logic [7:0] b, input logic s,
                          input logic ci, input logic ai, input logic [13:0] exp);
    apply(b, s, ci, ai);
    check(req, comb_out(), exp);
    @(posedge clk); #1;
    check(req, reg_out(), exp);
  endtask

  // R9: registered output holds until the edge
  task automatic t_latency();
    apply(8'h12, 1'b0, 1'b0, 1'b0);
    @(posedge clk);
    apply(8'h34, 1'b0, 1'b0, 1'b0);
    check("R9 hold", reg_out(), model(8'h12, 1'b0, 1'b0, 1'b0));
    @(posedge clk); #1;
    check("R9 update", reg_out(), model(8'h34, 1'b0, 1'b0, 1'b0));
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    byte_i = '0; sub_i = 0; cf_i = 0; af_i = 0;
    t_reset();
    // R4/R6/R7: 0x9A add -> 0x00, cf=1, af=1, zf=1, pf=1
    t_corner("R4 R6", 8'h9A, 1'b0, 1'b0, 1'b0, {8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0});
    // R3: 0x03 sub with af -> 0xFD, cf=1 from borrow threshold, odd parity
    t_corner("R3", 8'h03, 1'b1, 1'b0, 1'b1, {8'hFD, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
    // R3: 0x06 sub with af -> 0x00, no provisional carry
    t_corner("R3 edge", 8'h06, 1'b1, 1'b0, 1'b1, {8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0});
    // R2: 0xFA add -> 0x60, cf=1
    t_corner("R2", 8'hFA, 1'b0, 1'b0, 1'b0, {8'h60, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
    // R2: 0xF9 add with af -> low nibble 9 still fires via af; 0xFF then +0x60 -> 0x5F
    t_corner("R2 edge", 8'hF9, 1'b0, 1'b0, 1'b1, {8'h5F, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
    // R5: 0x45 add, nothing taken
    t_corner("R5", 8'h45, 1'b0, 1'b0, 1'b0, {8'h45, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
    // R4: carry in forces high step: 0x45 -> 0xA5
    t_corner("R4 cf", 8'h45, 1'b0, 1'b1, 1'b0, {8'hA5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0});
    // R1/R4: decision on original byte: 0x94 af add -> 0x9A, no high step
    t_corner("R1 R4 orig", 8'h94, 1'b0, 1'b0, 1'b1, {8'h9A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0});
    // R8: overflow stays clear on a large wrap
    t_corner("R8", 8'hFF, 1'b1, 1'b1, 1'b1, model(8'hFF, 1'b1, 1'b1, 1'b1));
    t_latency();
    t_sweep();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule